// File: doc/BRIEF.md
# Serial Audio Capture with Tap History

The block takes a serial stereo audio stream made of a bit clock, a word-select line and one data line. It picks out the channel named by a select input and keeps only the twelve most significant bits of each word on that channel. Each kept sample is pushed into a seven-entry history of recent samples. The newest sample sits at index 0 and the oldest at index 6.

A downstream filter datapath reads any entry of the history through a combinational read address, so it can walk the taps in whatever order it needs. All three serial lines are oversampled in the system clock domain and pass through synchronizers. A single-cycle strobe tells the datapath that a fresh sample has entered the history.

Top module: `i2s_tap_capture`

## Requirements
- R1: While reset is held and right after it is released, `new_sample` is low and every read address returns zero.
- R2: The serial lines are sampled on rising `sck` edges. `ws` low marks the left channel and `ws` high the right channel. The MSB of a word arrives one bit clock after the `ws` change, and the LSB arrives on the edge where `ws` changes again.
- R3: With `chan_sel` = 0 only left words are kept, and with `chan_sel` = 1 only right words. Words of the other channel leave the history unchanged and raise no strobe.
- R4: A word longer than 12 bits keeps only its upper 12 bits, and its first bit lands in bit 11. This holds for the default 24-bit words and for longer ones such as 32 bits.
- R5: A word shorter than 12 bits is placed left-aligned in the 12-bit sample, and the unused low bits are zero.
- R6: The word that ends at the first `ws` transition after reset is discarded, because its start was not observed.
- R7: Each kept sample enters the history at address 0 and every older entry moves up one address. After more than seven samples, address 0 holds the newest sample and address 6 the seventh newest.
- R8: A read address of 7 returns zero.
- R9: `new_sample` is high for exactly one system clock cycle per kept word. In that cycle address 0 already returns the new sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial bit clock |
| ws | input | 1 | Word select (0 left, 1 right) |
| sd | input | 1 | Serial data, MSB first |
| chan_sel | input | 1 | Channel to keep (0 left, 1 right) |
| rd_addr | input | 3 | History read index |
| rd_data | output | 12 | History entry at `rd_addr`, zero when out of range |
| new_sample | output | 1 | One-cycle strobe for each kept sample |

## Verification
A push into the history and a read of the tap it changes can happen in the same cycle. The bench holds `rd_addr` at 0 while words stream in and records `rd_data` in every cycle where `new_sample` is high. That recorded value must equal the word just completed, not the one before it. The strobe monitor also flags any strobe that lasts two cycles.

// File: rtl/i2s_hist_pkg.sv
`timescale 1ns/1ps
package i2s_hist_pkg;
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/i2s_line_sync.sv
`timescale 1ns/1ps
module i2s_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic bit_stb,
  output logic ws_bit,
  output logic sd_bit
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sck_q, ws_q, sd_q;
  logic [TOP:0] sck_n, ws_n, sd_n;
  logic         sck_last;

  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        sck_n = sck_in;
        ws_n  = ws_in;
        sd_n  = sd_in;
      end
    end else begin : g_many
      always_comb begin
        sck_n = {sck_q[TOP-1:0], sck_in};
        ws_n  = {ws_q[TOP-1:0], ws_in};
        sd_n  = {sd_q[TOP-1:0], sd_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= '0;
      ws_q     <= '0;
      sd_q     <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_q    <= sck_n;
      ws_q     <= ws_n;
      sd_q     <= sd_n;
      sck_last <= sck_q[TOP];
    end
  end

  assign bit_stb = sck_q[TOP] & ~sck_last;
  assign ws_bit  = ws_q[TOP];
  assign sd_bit  = sd_q[TOP];

  // R2: a rising bit clock edge yields a strobe of exactly one cycle
  a_r2_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
endmodule

// File: rtl/i2s_word_deser.sv
`timescale 1ns/1ps
module i2s_word_deser
  import i2s_hist_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int KEEP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_stb,
  input  logic              ws_bit,
  input  logic              sd_bit,
  input  logic              chan_sel,
  output logic              word_vld,
  output logic [KEEP_W-1:0] word
);
  localparam int CNT_MAX = (WORD_W > KEEP_W) ? WORD_W : KEEP_W;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              ws_prev_q, ws_prev_n;
  logic              primed_q, primed_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [KEEP_W-1:0] cap_q, cap_n, cap_ins;
  logic [KEEP_W-1:0] word_q, word_n;
  logic              vld_q, vld_n;

  always_comb begin
    ws_prev_n = ws_prev_q;
    primed_n  = primed_q;
    cnt_n     = cnt_q;
    cap_n     = cap_q;
    word_n    = word_q;
    vld_n     = 1'b0;
    cap_ins   = cap_q;
    for (int i = 0; i < KEEP_W; i++) begin
      if (cnt_q == CNT_W'(KEEP_W - 1 - i)) cap_ins[i] = sd_bit;
    end
    if (bit_stb) begin
      ws_prev_n = ws_bit;
      if (ws_bit != ws_prev_q) begin
        primed_n = 1'b1;
        cnt_n    = '0;
        cap_n    = '0;
        if (primed_q && (chan_e'(ws_prev_q) == chan_e'(chan_sel))) begin
          vld_n  = 1'b1;
          word_n = cap_ins;
        end
      end else begin
        cap_n = cap_ins;
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_prev_q <= 1'b0;
      primed_q  <= 1'b0;
      cnt_q     <= '0;
      cap_q     <= '0;
      word_q    <= '0;
      vld_q     <= 1'b0;
    end else begin
      ws_prev_q <= ws_prev_n;
      primed_q  <= primed_n;
      cnt_q     <= cnt_n;
      cap_q     <= cap_n;
      word_q    <= word_n;
      vld_q     <= vld_n;
    end
  end

  assign word_vld = vld_q;
  assign word     = word_q;

  // R2: a finished word is only reported right after a bit clock edge
  a_r2_word_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld |-> $past(bit_stb));
endmodule

// File: rtl/i2s_tap_hist.sv
`timescale 1ns/1ps
module i2s_tap_hist #(
  parameter int DEPTH  = 7,
  parameter int KEEP_W = 12,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [KEEP_W-1:0] din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [KEEP_W-1:0] rd_data,
  output logic              pushed
);
  logic [KEEP_W-1:0] hist_q [DEPTH];
  logic [KEEP_W-1:0] hist_n [DEPTH];
  logic              pushed_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      if (i == 0) begin : g_head
        always_comb hist_n[i] = push ? din : hist_q[i];
      end else begin : g_body
        always_comb hist_n[i] = push ? hist_q[i-1] : hist_q[i];
        // R7: each push moves the older entry up one address
        a_r7_shift: assert property (@(posedge clk) disable iff (!rst_n)
          push |=> hist_q[i] == $past(hist_q[i-1]));
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q[i] <= '0;
        else        hist_q[i] <= hist_n[i];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pushed_q <= 1'b0;
    else        pushed_q <= push;
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_addr == ADDR_W'(i)) rd_data = hist_q[i];
    end
  end

  assign pushed = pushed_q;

  // R9: the strobe never lasts longer than one cycle
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pushed |=> !pushed);
  // R7: the head entry holds its value unless a push occurs
  a_r7_hold_head: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(hist_q[0]));
endmodule

// File: rtl/i2s_tap_capture.sv
`timescale 1ns/1ps
module i2s_tap_capture #(
  parameter int WORD_W      = 24,
  parameter int KEEP_W      = 12,
  parameter int DEPTH       = 7,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ws,
  input  logic              sd,
  input  logic              chan_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [KEEP_W-1:0] rd_data,
  output logic              new_sample
);
  logic [1:0]        rst_pipe;
  logic              rst_core_n;
  logic              bit_stb, ws_bit, sd_bit;
  logic              word_vld;
  logic [KEEP_W-1:0] word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  i2s_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .sck_in  (sck),
    .ws_in   (ws),
    .sd_in   (sd),
    .bit_stb (bit_stb),
    .ws_bit  (ws_bit),
    .sd_bit  (sd_bit)
  );

  i2s_word_deser #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_deser (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .bit_stb  (bit_stb),
    .ws_bit   (ws_bit),
    .sd_bit   (sd_bit),
    .chan_sel (chan_sel),
    .word_vld (word_vld),
    .word     (word)
  );

  i2s_tap_hist #(.DEPTH(DEPTH), .KEEP_W(KEEP_W), .ADDR_W(ADDR_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .push    (word_vld),
    .din     (word),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pushed  (new_sample)
  );
endmodule

// File: tb/sim_i2s_tap_capture.sv
`timescale 1ns/1ps
module sim_i2s_tap_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, ws = 1'b0, sd = 1'b0, chan_sel = 1'b0;
  logic [2:0]  rd_addr = 3'd0;
  logic [11:0] rd_data;
  logic        new_sample;

  int checks = 0, errors = 0, pulses = 0, dbl = 0;
  logic        prev_ns = 1'b0;
  logic        tail_bit = 1'b0;
  logic [11:0] strobe_val = '0;

  always #2.5 clk = ~clk;

  i2s_tap_capture u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .ws(ws), .sd(sd),
    .chan_sel(chan_sel), .rd_addr(rd_addr), .rd_data(rd_data),
    .new_sample(new_sample)
  );

  always @(negedge clk) begin
    if (new_sample) begin
      pulses++;
      strobe_val = rd_data;
      if (prev_ns) dbl++;
    end
    prev_ns = new_sample;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mask(input logic [31:0] v, input int len);
    if (len >= 32) return v;
    return v & ((32'd1 << len) - 32'd1);
  endfunction

  function automatic logic [11:0] top12(input logic [31:0] v, input int len);
    if (len >= 12) return 12'(v >> (len - 12));
    return 12'(v << (12 - len));
  endfunction

  task automatic put_bit(input logic w, input logic b);
    ws = w; sd = b;
    #40 sck = 1'b1;
    #40 sck = 1'b0;
  endtask

  task automatic send_word(input logic w, input int len, input logic [31:0] v);
    put_bit(w, tail_bit);
    for (int i = len - 1; i >= 1; i--) put_bit(w, v[i]);
    tail_bit = v[0];
  endtask

  task automatic flush();
    put_bit(~ws, tail_bit);
    #200;
    @(negedge clk);
  endtask

  task automatic read_at(input int a, output logic [11:0] d);
    rd_addr = 3'(a);
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic apply_reset(input logic sel);
    rst_n = 1'b0; sck = 1'b0; ws = 1'b0; sd = 1'b0;
    tail_bit = 1'b0; chan_sel = sel; rd_addr = 3'd0;
    repeat (4) @(negedge clk);
    chk("R1 strobe low in reset", 32'(new_sample), 32'd0);
    pulses = 0; dbl = 0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [31:0] lval(input int k, input int len);
    return mask(32'hA53C_6E91 ^ (32'(k) * 32'h0F1D_2B37), len);
  endfunction

  function automatic logic [31:0] rval(input int k, input int len);
    return mask(32'h3C96_D12B ^ (32'(k) * 32'h1357_9BDF), len);
  endfunction

  task automatic t_reset();
    logic [11:0] d;
    apply_reset(1'b0);
    for (int a = 0; a < 8; a++) begin
      read_at(a, d);
      chk($sformatf("R1 reset tap %0d", a), 32'(d), 32'd0);
    end
    chk("R1 no strobe after reset", 32'(pulses), 32'd0);
  endtask

  task automatic t_discard_first();
    logic [11:0] d;
    apply_reset(1'b0);
    send_word(1'b0, 24, lval(0, 24));
    send_word(1'b1, 24, rval(0, 24));
    flush();
    chk("R6 first left word dropped", 32'(pulses), 32'd0);
    read_at(0, d);
    chk("R6 history still empty", 32'(d), 32'd0);
  endtask

  task automatic t_left_history();
    logic [11:0] d;
    apply_reset(1'b0);
    for (int k = 0; k < 9; k++) begin
      send_word(1'b0, 24, lval(k, 24));
      send_word(1'b1, 24, rval(k, 24));
    end
    flush();
    chk("R3 R6 left strobe count", 32'(pulses), 32'd8);
    chk("R9 no double strobe", 32'(dbl), 32'd0);
    chk("R9 tap 0 valid with strobe", 32'(strobe_val), 32'(top12(lval(8, 24), 24)));
    for (int a = 0; a < 7; a++) begin
      read_at(a, d);
      chk($sformatf("R7 R4 left tap %0d", a), 32'(d), 32'(top12(lval(8 - a, 24), 24)));
    end
    read_at(7, d);
    chk("R8 address 7 reads zero", 32'(d), 32'd0);
  endtask

  task automatic t_right_select();
    logic [11:0] d;
    apply_reset(1'b1);
    for (int k = 0; k < 4; k++) begin
      send_word(1'b0, 24, lval(k, 24));
      send_word(1'b1, 24, rval(k, 24));
    end
    flush();
    chk("R3 right strobe count", 32'(pulses), 32'd4);
    for (int a = 0; a < 4; a++) begin
      read_at(a, d);
      chk($sformatf("R3 R2 right tap %0d", a), 32'(d), 32'(top12(rval(3 - a, 24), 24)));
    end
    read_at(4, d);
    chk("R7 unfilled tap 4 zero", 32'(d), 32'd0);
  endtask

  task automatic t_length(input int len, input string tag);
    logic [11:0] d;
    apply_reset(1'b0);
    for (int k = 0; k < 3; k++) begin
      send_word(1'b0, len, lval(k, len));
      send_word(1'b1, len, rval(k, len));
    end
    flush();
    chk({tag, " strobe count"}, 32'(pulses), 32'd2);
    read_at(0, d);
    chk({tag, " newest"}, 32'(d), 32'(top12(lval(2, len), len)));
    read_at(1, d);
    chk({tag, " older"}, 32'(d), 32'(top12(lval(1, len), len)));
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_discard_first();
    t_left_history();
    t_right_select();
    t_length(8, "R5 short word");
    t_length(32, "R4 long word");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule